// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog built around a 64-bit up-counter and a 64-bit period. Software starts the counter through a small global-control register, then arms the watchdog by writing two magic keys, one after the other, into the key field (bits [31:16]) of the watchdog-control register. Bit 14 of the first write must also be set. Once armed, the watchdog raises its reset output when the counter catches up with the period, or straight away when software writes a key that is not one of the two valid keys.

Software keeps an armed watchdog quiet by writing the same two keys in order, which clears the counter. After arming, software cannot disarm the block and cannot stop its counter. Only the system reset input returns it to the idle state. The reset output is a pulse of fixed length. The SoC reset logic consumes it.

The register port is a plain 32-bit word interface. A write happens in any cycle with the write strobe high. Read data follows the address combinationally.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the reset output is low, the key state is idle, and every register word reads zero.
- R2: The counter advances by one per clock only while global-control bits [3:2] are 2'b10 (watchdog mode) and bits [1:0] are 2'b11 (released). For any other value it holds. Global control is at word address 0 and reads back in bits [3:0].
- R3: The counter is at word addresses 2 (low half) and 3 (high half). The period is at word addresses 4 (low half) and 5 (high half). A write to a word loads that word. The low half carries into the high half when it wraps.
- R4: In idle, a watchdog-control write (word address 1) with key 0xA5C6 in bits [31:16] and bit 14 set enters pre-active. Any other write, including key 0xA5C6 with bit 14 clear, leaves the block idle and does not pulse the reset output.
- R5: In pre-active, key 0xDA7E enters active and key 0xA5C6 stays in pre-active. Any other key returns to idle without a reset pulse.
- R6: In active, key 0xA5C6 followed by key 0xDA7E clears the counter to 0 on the edge that takes the second write. Key 0xDA7E alone leaves the counter running and causes no reset.
- R7: In active, including after a 0xA5C6 write, a key other than 0xA5C6 or 0xDA7E raises the reset output from the clock edge that takes the write.
- R8: In active, while the counter equals the period, the next edge raises the reset output and clears the counter to 0.
- R9: Each trigger holds the reset output high for exactly 16 clocks.
- R10: Watchdog-control reads return the active flag in bit 14 and the key state in bits [13:12] (0 idle, 1 pre-active, 2 active, 3 active after 0xA5C6). Once active, the block stays active whatever bit 14 holds, until the reset input is asserted.
- R11: While active, writes to global control are ignored.
- R12: Outside active, the counter reaching the period has no effect on the reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| wd_rst_o | output | 1 | Watchdog reset request |

## Verification
A key state that is wrong shows up on the port one cycle after a write. Either the watchdog-control read-back code differs, or wd_rst_o rises where it should stay low or stays low where it should rise. A fault in the counter or the comparison shows up as a timeout that comes at the wrong clock. The bench counts that delay exactly, as period plus one edges after a service. Faults in the pulse stretcher show up as a pulse that is not 16 samples wide. They also show up as a second timeout that does not follow a full period later.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;
  localparam int WORD_W = 32;
  localparam int NWORD  = 2;
  localparam int CNT_W  = WORD_W * NWORD;
  localparam int ADDR_W = 3;
  localparam int KEY_W  = 16;
  localparam int KEY_LSB = 16;
  localparam int EN_BIT  = 14;
  localparam int ST_LSB  = 12;

  localparam logic [ADDR_W-1:0] A_GCTL = 3'd0;
  localparam logic [ADDR_W-1:0] A_WCTL = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRD0 = 3'd4;

  localparam logic [KEY_W-1:0] KEY_ARM = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_SVC = 16'hDA7E;
  localparam logic [3:0]       GCTL_RUN = 4'b1011;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_PRE  = 2'd1,
    WS_ACT  = 2'd2,
    WS_ARMD = 2'd3
  } wd_state_e;

  function automatic logic is_active(input wd_state_e s);
    return (s == WS_ACT) || (s == WS_ARMD);
  endfunction

  function automatic wd_state_e key_step(input wd_state_e s,
                                         input logic [KEY_W-1:0] k,
                                         input logic en);
    wd_state_e n;
    case (s)
      WS_IDLE: n = (k == KEY_ARM && en) ? WS_PRE : WS_IDLE;
      WS_PRE:  n = (k == KEY_SVC) ? WS_ACT : ((k == KEY_ARM) ? WS_PRE : WS_IDLE);
      WS_ACT:  n = (k == KEY_ARM) ? WS_ARMD : WS_ACT;
      default: n = (k == KEY_SVC) ? WS_ACT : WS_ARMD;
    endcase
    return n;
  endfunction

  function automatic logic key_bad(input wd_state_e s, input logic [KEY_W-1:0] k);
    return is_active(s) && (k != KEY_ARM) && (k != KEY_SVC);
  endfunction

  function automatic logic key_service(input wd_state_e s, input logic [KEY_W-1:0] k);
    return (s == WS_ARMD) && (k == KEY_SVC);
  endfunction
endpackage

// File: rtl/wdk_keyfsm.sv
`timescale 1ns/1ps
module wdk_keyfsm import wdk_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  input  logic             en,
  output wd_state_e        state_q,
  output logic             svc_evt,
  output logic             bad_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= WS_IDLE;
    else if (key_wr) state_q <= key_step(state_q, key, en);
  end

  assign svc_evt = key_wr && key_service(state_q, key);
  assign bad_evt = key_wr && key_bad(state_q, key);
endmodule

// File: rtl/wdk_count64.sv
`timescale 1ns/1ps
module wdk_count64 import wdk_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [NWORD-1:0]  cnt_ld,
  input  logic [NWORD-1:0]  prd_ld,
  input  logic [WORD_W-1:0] ld_data,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  prd_q,
  output logic              match
);
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (run) cnt_nx = cnt_q + CNT_W'(1);
    for (int w = 0; w < NWORD; w++) begin
      if (cnt_ld[w]) cnt_nx[w*WORD_W +: WORD_W] = ld_data;
    end
    if (clr) cnt_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_prd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prd_q[w*WORD_W +: WORD_W] <= '0;
      else if (prd_ld[w]) prd_q[w*WORD_W +: WORD_W] <= ld_data;
    end
  end

  assign match = (cnt_q == prd_q);
endmodule

// File: rtl/wdk_rstgen.sv
`timescale 1ns/1ps
module wdk_rstgen #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_o
);
  localparam int HW = $clog2(HOLD + 1);
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hold_q <= '0;
    else if (fire)         hold_q <= HW'(HOLD);
    else if (hold_q != '0) hold_q <= hold_q - HW'(1);
  end

  assign rst_o = (hold_q != '0);
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed import wdk_pkg::*; #(
  parameter int RST_HOLD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              wd_rst_o
);
  wd_state_e        state_q;
  logic             svc_evt, bad_evt, timeout_evt, fire_evt;
  logic             active, key_wr, gctl_try, gctl_we, match;
  logic [3:0]       gctl_q;
  logic [NWORD-1:0] cnt_ld, prd_ld;
  logic [CNT_W-1:0] cnt_q, prd_q;

  assign key_wr   = reg_wr && (reg_addr == A_WCTL);
  assign gctl_try = reg_wr && (reg_addr == A_GCTL);
  assign active   = is_active(state_q);
  assign gctl_we  = gctl_try && !active;

  for (genvar w = 0; w < NWORD; w++) begin : g_dec
    assign cnt_ld[w] = reg_wr && (reg_addr == A_CNT0 + ADDR_W'(w));
    assign prd_ld[w] = reg_wr && (reg_addr == A_PRD0 + ADDR_W'(w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gctl_q <= '0;
    else if (gctl_we) gctl_q <= reg_wdata[3:0];
  end

  wdk_keyfsm u_fsm (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
    .key(reg_wdata[KEY_LSB +: KEY_W]), .en(reg_wdata[EN_BIT]),
    .state_q(state_q), .svc_evt(svc_evt), .bad_evt(bad_evt)
  );

  assign timeout_evt = active && match;
  assign fire_evt    = bad_evt || timeout_evt;

  wdk_count64 u_cnt (
    .clk(clk), .rst_n(rst_n), .run(gctl_q == GCTL_RUN),
    .clr(svc_evt || timeout_evt), .cnt_ld(cnt_ld), .prd_ld(prd_ld),
    .ld_data(reg_wdata), .cnt_q(cnt_q), .prd_q(prd_q), .match(match)
  );

  wdk_rstgen #(.HOLD(RST_HOLD)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(fire_evt), .rst_o(wd_rst_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_GCTL) reg_rdata[3:0] = gctl_q;
    if (reg_addr == A_WCTL) begin
      reg_rdata[EN_BIT]        = active;
      reg_rdata[ST_LSB +: 2]   = state_q;
    end
    for (int w = 0; w < NWORD; w++) begin
      if (reg_addr == A_CNT0 + ADDR_W'(w)) reg_rdata = cnt_q[w*WORD_W +: WORD_W];
      if (reg_addr == A_PRD0 + ADDR_W'(w)) reg_rdata = prd_q[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/wdk_chk.sv
`timescale 1ns/1ps
module wdk_chk import wdk_pkg::*; #(
  parameter int RST_HOLD = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state,
  input logic             svc_evt,
  input logic             bad_evt,
  input logic             timeout_evt,
  input logic [CNT_W-1:0] cnt,
  input logic             gctl_try,
  input logic [3:0]       gctl,
  input logic             wd_rst
);
  localparam int AW = $clog2(RST_HOLD + 1);
  logic [AW-1:0] age_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      seen_q <= 1'b0;
    end else if (bad_evt || timeout_evt) begin
      age_q  <= '0;
      seen_q <= 1'b1;
    end else if (seen_q && age_q != AW'(RST_HOLD)) begin
      age_q  <= age_q + AW'(1);
    end
  end

  // R10
  state_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state[1] |=> state[1]);
  // R5
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |=> !state[1]);
  // R6
  svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_evt |=> (cnt == '0));
  // R7
  bad_key_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> wd_rst);
  // R8
  timeout_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (wd_rst && cnt == '0));
  // R9
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst) |-> $past(bad_evt || timeout_evt));
  // R9
  rst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (wd_rst == (age_q < AW'(RST_HOLD))));
  // R12
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !wd_rst);
  // R11
  gctl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state[1] && gctl_try) |=> $stable(gctl));
endmodule

bind wdog_keyed wdk_chk #(.RST_HOLD(RST_HOLD)) u_wdk_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .svc_evt(svc_evt),
  .bad_evt(bad_evt), .timeout_evt(timeout_evt), .cnt(cnt_q),
  .gctl_try(gctl_try), .gctl(gctl_q), .wd_rst(wd_rst_o)
);

// File: tb/wdog_keyed_bench.sv
`timescale 1ns/1ps
module wdog_keyed_bench;
  localparam logic [2:0] AG = 3'd0, AW = 3'd1, ACL = 3'd2, ACH = 3'd3, APL = 3'd4, APH = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wd_rst_o;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  wdog_keyed u_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wd_rst_o(wd_rst_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    waitn(2);
    rst_n = 1'b1;
    waitn(1);
  endtask

  task automatic arm();
    wr(AW, 32'hA5C6_4000);
    wr(AW, 32'hDA7E_4000);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    chk("R1 rst_out", 64'(wd_rst_o), 64'd0);
    rd(AG, d);  chk("R1 gctl", 64'(d), 64'd0);
    rd(AW, d);  chk("R1 wctl", 64'(d), 64'd0);
    rd(ACL, d); chk("R1 cnt", 64'(d), 64'd0);
    rd(APH, d); chk("R1 prd", 64'(d), 64'd0);
  endtask

  task automatic t_gctl_modes();
    logic [31:0] d;
    do_reset();
    wr(AG, 32'h8); waitn(5); rd(ACL, d); chk("R2 mode only held", 64'(d), 64'd0);
    wr(AG, 32'h7); waitn(5); rd(ACL, d); chk("R2 wrong mode held", 64'(d), 64'd0);
    wr(AG, 32'hB); rd(AG, d); chk("R2 gctl readback", 64'(d), 64'hB);
    waitn(5); rd(ACL, d); chk("R2 counting", 64'(d), 64'd5);
    wr(AG, 32'h3); waitn(4); rd(ACL, d); chk("R2 stopped", 64'(d), 64'd6);
  endtask

  task automatic t_words_carry();
    logic [31:0] lo, hi;
    do_reset();
    wr(ACL, 32'hFFFF_FFFE);
    rd(ACL, lo); chk("R3 cnt load", 64'(lo), 64'hFFFF_FFFE);
    wr(APH, 32'h1234_5678); wr(APL, 32'h9ABC_DEF0);
    rd(APH, hi); rd(APL, lo); chk("R3 prd words", {hi, lo}, 64'h1234_5678_9ABC_DEF0);
    wr(AG, 32'hB); waitn(3);
    rd(ACH, hi); rd(ACL, lo); chk("R3 carry", {hi, lo}, 64'h1_0000_0001);
  endtask

  task automatic t_idle_keys();
    logic [31:0] d;
    int hi_seen = 0;
    do_reset();
    wr(APL, 32'd3); wr(AG, 32'hB);
    wr(AW, 32'h1234_4000); rd(AW, d); chk("R4 idle bad key", 64'(d), 64'd0);
    wr(AW, 32'hA5C6_0000); rd(AW, d); chk("R4 arm without enable", 64'(d), 64'd0);
    wr(AW, 32'hDA7E_4000); rd(AW, d); chk("R4 second key in idle", 64'(d), 64'd0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (wd_rst_o) hi_seen++;
    end
    chk("R12 idle period match no reset", 64'(hi_seen), 64'd0);
    wr(AW, 32'hA5C6_4000); rd(AW, d); chk("R4 enter pre-active", 64'(d), 64'h1000);
  endtask

  task automatic t_pre_keys();
    logic [31:0] d;
    wr(AW, 32'hA5C6_4000); rd(AW, d); chk("R5 arm key stays pre", 64'(d), 64'h1000);
    wr(AW, 32'h0000_4000); rd(AW, d); chk("R5 wrong key to idle", 64'(d), 64'd0);
    chk("R5 no reset in pre", 64'(wd_rst_o), 64'd0);
    arm(); rd(AW, d); chk("R5 enter active", 64'(d), 64'h6000);
    chk("R5 no reset on arming", 64'(wd_rst_o), 64'd0);
  endtask

  task automatic t_service();
    logic [31:0] d;
    int hi_seen = 0;
    do_reset();
    wr(APL, 32'd40); wr(AG, 32'hB); arm();
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (wd_rst_o) hi_seen++;
      end
      wr(AW, 32'hA5C6_0000); rd(AW, d);
      chk("R10 armed code, enable kept", 64'(d), 64'h7000);
      wr(AW, 32'hDA7E_0000); rd(ACL, d);
      chk("R6 service clears", 64'(d), 64'd0);
    end
    chk("R6 no reset while serviced", 64'(hi_seen), 64'd0);
    wr(AW, 32'hDA7E_4000); rd(ACL, d); chk("R6 lone second key no clear", 64'(d), 64'd1);
    rd(AW, d); chk("R6 lone second key state", 64'(d), 64'h6000);
    chk("R6 lone second key no reset", 64'(wd_rst_o), 64'd0);
    wr(AG, 32'h0); rd(AG, d); chk("R11 gctl locked", 64'(d), 64'hB);
    waitn(3); rd(ACL, d); chk("R11 counter keeps running", 64'(d), 64'd5);
    do_reset(); rd(AW, d); chk("R10 reset returns idle", 64'(d), 64'd0);
  endtask

  task automatic t_bad_key();
    logic [31:0] d;
    int width;
    do_reset();
    wr(APL, 32'd1000); wr(AG, 32'hB); arm();
    wr(AW, 32'hBEEF_4000);
    chk("R7 bad key immediate reset", 64'(wd_rst_o), 64'd1);
    width = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (wd_rst_o) width++;
    end
    chk("R9 bad key pulse width", 64'(width), 64'd16);
    rd(AW, d); chk("R10 active after firing", 64'(d), 64'h6000);
    wr(AW, 32'hA5C6_4000); wr(AW, 32'h0000_4000);
    chk("R7 bad key after arm key", 64'(wd_rst_o), 64'd1);
    waitn(20);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    int first = 0, second = 0, rises = 0, width = 0;
    logic prev = 1'b0;
    do_reset();
    wr(APL, 32'd25); wr(AG, 32'hB); arm();
    wr(AW, 32'hA5C6_4000); wr(AW, 32'hDA7E_4000);
    for (int n = 1; n <= 60; n++) begin
      @(negedge clk);
      if (wd_rst_o && !prev) begin
        rises++;
        if (rises == 1) begin
          first = n;
          rd(ACL, d); chk("R8 counter cleared on timeout", 64'(d), 64'd0);
        end
        if (rises == 2) second = n;
      end
      if (wd_rst_o && rises == 1) width++;
      prev = wd_rst_o;
    end
    chk("R8 timeout delay", 64'(first), 64'd26);
    chk("R9 timeout pulse width", 64'(width), 64'd16);
    chk("R8 repeat timeout", 64'(second), 64'd52);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    waitn(1);
    t_reset_state();
    t_gctl_modes();
    t_words_carry();
    t_idle_keys();
    t_pre_keys();
    t_service();
    t_bad_key();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule